// File: doc/BRIEF.md
# Serial Wire Debug Transaction Engine

This block is the host end of a two-wire debug link. It takes one register request at a time and turns it into a complete packet on the wire. It drives the debug clock and the data line. The data line is modelled as three signals: an output value, an output enable and a sampled input. A request selects the debug port or the access port, a read or a write, and a two-bit register address. For writes it also carries a data word.

For each packet the engine sends a short run of low lead-in cycles and then an 8-bit header. It reads back the target's 3-bit acknowledge. It then moves the data phase in the direction that the request and the acknowledge call for. When the packet ends it pulses `done` for one cycle and reports the acknowledge, the read word and a read-parity error.

A special target-select mode writes to a target that does not answer the header. The engine clocks five response cycles without looking at the line and then sends the data word. The bit rate is set by a parameter: each bit takes `2*CLK_HALF` system clocks, and `CLK_HALF` must be at least 2.

Top module: `swd_engine`

## Requirements
- R1: Each bit occupies one slot of `2*CLK_HALF` clocks. The host bit is put on the line while `swclk` is low. `swclk` is then high for exactly `CLK_HALF` clocks and falls before the slot ends. The input is captured on the last clock of the slot, after the falling edge. `swclk` stays low while the engine is not busy.
- R2: Every packet starts with two slots in which the line is driven low (`swdio_oe`=1, `swdio_out`=0).
- R3: Slots 2 to 9 carry the header in this order: 1, port select (1 = access port), read flag (1 = read), address bit 0, address bit 1, the XOR of those four request bits, 0, 1.
- R4: Slots 10 to 12 sample the acknowledge. The first received bit lands in `resp_ack[0]`. The codes are 3'b001 OK, 3'b010 WAIT and 3'b100 FAULT. Any value other than OK ends the packet after slot 12 (13 slots in total), with no data phase, and that value is reported on `resp_ack`.
- R5: A write with OK leaves the line undriven for two turnaround slots (13 and 14). It then drives the 32 data bits LSB first in slots 15 to 46, and in slot 47 the XOR of the data bits (48 slots in total).
- R6: A read with OK samples 32 data bits LSB first in slots 13 to 44 and a parity bit in slot 45 (46 slots in total). The data appears on `resp_rdata`. `resp_parity_err` is 1 exactly when the parity bit differs from the XOR of the received data. On any other packet `resp_parity_err` is 0.
- R7: With `req_tsel`=1, slots 10 to 14 are left undriven and the line is ignored in them. The data and parity are then driven in slots 15 to 47 whatever the target returned, and `resp_ack` reads 3'b000.
- R8: `swdio_oe` is 0 in the acknowledge, turnaround, target-select response and read-data slots. It is 1 in all other slots and whenever the engine is idle, where `swdio_out` is 0.
- R9: A request is taken only when `req_valid` is 1 and `busy` is 0. A request raised while busy has no effect on the packet in flight. `done` is high for exactly one clock, and `busy` is already 0 in that clock.
- R10: After reset, `swclk`=0, `swdio_oe`=1, `swdio_out`=0, `busy`=0, `done`=0 and `resp_ack`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_ap | input | 1 | 1 selects the access port, 0 the debug port |
| req_read | input | 1 | 1 for a read, 0 for a write |
| req_addr | input | 2 | Register address bits [3:2] |
| req_tsel | input | 1 | Target-select write: response slots ignored |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-clock end-of-packet strobe |
| resp_ack | output | 3 | Received acknowledge, first bit in bit 0 |
| resp_rdata | output | DATA_W | Read data |
| resp_parity_err | output | 1 | Read parity mismatch |
| swclk | output | 1 | Debug clock to target |
| swdio_out | output | 1 | Data line output value |
| swdio_oe | output | 1 | Data line output enable |
| swdio_in | input | 1 | Data line sampled input |

## Verification
The engine is a slot-counted state machine, so a wrong phase or bit counter shows up as a changed slot count by the time `done` rises. Before that, it shows as a header or output-enable pattern that goes wrong from the very slot where the state diverges: within the first ten slots for lead-in and header faults, and at slot 10 for a late release of the line. A wrong shift or capture path corrupts `resp_ack`, `resp_rdata` or the driven write bits in the same packet. A wrong parity decision flips `resp_parity_err`, which is visible at `done`. Timer faults change the `swclk` high time or the rise-to-rise spacing inside the first packet.

// File: rtl/swd_pkg.sv
// Shared types and helpers for the serial wire debug engine.
// Assumes least-significant-bit-first ordering on the wire.
package swd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HDR,
        ST_ACK,
        ST_TURN,
        ST_TSEL,
        ST_WDAT,
        ST_RDAT
    } seq_state_t;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;

    localparam int LEAD_SLOTS = 2;
    localparam int HDR_BITS   = 8;
    localparam int ACK_BITS   = 3;
    localparam int TURN_SLOTS = 2;
    localparam int TSEL_SLOTS = 5;

    // Header, bit 0 leaves first: start, port, dir, a2, a3, parity, stop, park.
    function automatic logic [HDR_BITS-1:0] make_header(input logic ap,
                                                       input logic rd,
                                                       input logic [1:0] addr);
        logic par;
        par = ap ^ rd ^ addr[0] ^ addr[1];
        return {1'b1, 1'b0, par, addr[1], addr[0], rd, ap, 1'b1};
    endfunction

endpackage

// File: rtl/swd_bitclk.sv
// Bit slot timer. While run is high it splits time into slots of
// 2*HALF clocks: clock 0 low (data setup), clocks 1..HALF high, the rest
// low. slot_end marks the last clock of a slot, after the falling edge.
// Assumes HALF >= 2 so that at least one low clock follows the fall.
module swd_bitclk #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic swclk,
    output logic slot_end
);
    localparam int PERIOD = 2 * HALF;
    localparam int CW     = $clog2(PERIOD);

    logic [CW-1:0] cnt;

    // Slot phase counter, held at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == CW'(PERIOD - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Decode the clock level and the end-of-slot strobe from the phase.
    always_comb begin
        swclk    = run && (cnt >= CW'(1)) && (cnt <= CW'(HALF));
        slot_end = run && (cnt == CW'(PERIOD - 1));
    end

    // R1: the capture point comes after the clock has fallen.
    a_r1_end_low: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end |-> !swclk);

    // R1: the clock never falls while the timer is stopped mid-slot.
    a_r1_fall_running: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(swclk) |-> run);

endmodule

// File: rtl/swd_seq.sv
// Packet sequencer. Takes one request, walks the lead-in, header,
// acknowledge, turnaround and data phases one slot at a time, and owns the
// single shift register used for both directions of the data line.
// Assumes slot_end comes from swd_bitclk running while busy_o is high.
module swd_seq
    import swd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_ap,
    input  logic              req_rd,
    input  logic [1:0]        req_addr,
    input  logic              req_tsel,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              slot_end,
    input  logic              swdio_in,
    output logic              busy_o,
    output logic              done_o,
    output logic [2:0]        ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              parity_err_o,
    output logic              swdio_out_o,
    output logic              swdio_oe_o
);
    localparam int SH_W  = DATA_W + 1;
    localparam int CNT_W = $clog2(SH_W);

    seq_state_t            state;
    logic [CNT_W-1:0]      bcnt;
    logic [CNT_W-1:0]      lim;
    logic                  last;
    logic [SH_W-1:0]       sh;
    logic [SH_W-1:0]       sh_in;
    logic [2:0]            ack_sh;
    logic [2:0]            ack_in;
    logic [HDR_BITS-1:0]   hdr_q;
    logic                  rnw_q;
    logic                  tsel_q;
    logic [DATA_W-1:0]     wdata_q;
    logic                  oe_q;

    // Slot count of the current phase, minus one.
    always_comb begin
        case (state)
            ST_LEAD: lim = CNT_W'(LEAD_SLOTS - 1);
            ST_HDR:  lim = CNT_W'(HDR_BITS - 1);
            ST_ACK:  lim = CNT_W'(ACK_BITS - 1);
            ST_TURN: lim = CNT_W'(TURN_SLOTS - 1);
            ST_TSEL: lim = CNT_W'(TSEL_SLOTS - 1);
            ST_WDAT: lim = CNT_W'(SH_W - 1);
            ST_RDAT: lim = CNT_W'(SH_W - 1);
            default: lim = '0;
        endcase
    end

    // Incoming bits enter at the top so the first received ends at bit 0.
    always_comb begin
        last   = (bcnt == lim);
        sh_in  = {swdio_in, sh[SH_W-1:1]};
        ack_in = {swdio_in, ack_sh[2:1]};
    end

    // Main phase machine and datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bcnt    <= '0;
            sh      <= '0;
            ack_sh  <= '0;
            ack_o   <= '0;
            rdata_o <= '0;
            parity_err_o <= 1'b0;
            hdr_q   <= '0;
            rnw_q   <= 1'b0;
            tsel_q  <= 1'b0;
            wdata_q <= '0;
            oe_q    <= 1'b1;
            busy_o  <= 1'b0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (state == ST_IDLE) begin
                if (req) begin
                    state        <= ST_LEAD;
                    bcnt         <= '0;
                    sh           <= '0;
                    ack_sh       <= '0;
                    ack_o        <= '0;
                    parity_err_o <= 1'b0;
                    hdr_q        <= make_header(req_ap, req_rd, req_addr);
                    rnw_q        <= req_rd;
                    tsel_q       <= req_tsel;
                    wdata_q      <= req_wdata;
                    oe_q         <= 1'b1;
                    busy_o       <= 1'b1;
                end
            end else if (slot_end) begin
                bcnt <= last ? '0 : bcnt + 1'b1;
                case (state)
                    ST_LEAD: begin
                        if (last) begin
                            state <= ST_HDR;
                            sh    <= {{(SH_W-HDR_BITS){1'b0}}, hdr_q};
                        end
                    end
                    ST_HDR: begin
                        sh <= sh >> 1;
                        if (last) begin
                            oe_q  <= 1'b0;
                            state <= tsel_q ? ST_TSEL : ST_ACK;
                        end
                    end
                    ST_ACK: begin
                        ack_sh <= ack_in;
                        if (last) begin
                            ack_o <= ack_in;
                            if (ack_in == ACK_OK) begin
                                state <= rnw_q ? ST_RDAT : ST_TURN;
                            end else begin
                                state  <= ST_IDLE;
                                busy_o <= 1'b0;
                                done_o <= 1'b1;
                                oe_q   <= 1'b1;
                                sh     <= '0;
                            end
                        end
                    end
                    ST_TURN, ST_TSEL: begin
                        if (last) begin
                            state <= ST_WDAT;
                            sh    <= {^wdata_q, wdata_q};
                            oe_q  <= 1'b1;
                        end
                    end
                    ST_WDAT: begin
                        sh <= sh >> 1;
                        if (last) begin
                            state  <= ST_IDLE;
                            busy_o <= 1'b0;
                            done_o <= 1'b1;
                            sh     <= '0;
                        end
                    end
                    ST_RDAT: begin
                        sh <= sh_in;
                        if (last) begin
                            rdata_o      <= sh_in[DATA_W-1:0];
                            parity_err_o <= ^sh_in;
                            state        <= ST_IDLE;
                            busy_o       <= 1'b0;
                            done_o       <= 1'b1;
                            oe_q         <= 1'b1;
                            sh           <= '0;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Line drive: the shift register low bit, released when not enabled.
    always_comb begin
        swdio_oe_o  = oe_q;
        swdio_out_o = oe_q & sh[0];
    end

    // R9: done is a single-clock strobe.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9: the engine is free again in the clock that reports completion.
    a_r9_done_free: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R9: captured request fields hold while a packet is in flight.
    a_r9_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy_o) && busy_o) |-> ($stable(hdr_q) && $stable(wdata_q)));

    // R8: the line is released in every slot the target may drive.
    a_r8_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK || state == ST_TURN || state == ST_TSEL ||
         state == ST_RDAT) |-> !swdio_oe_o);

    // R2: lead-in slots drive the line low.
    a_r2_lead_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAD) |-> (swdio_oe_o && !swdio_out_o));

    // R6: a parity error can only come out of a read.
    a_r6_perr_read: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !rnw_q) |-> !parity_err_o);

endmodule

// File: rtl/swd_engine.sv
// Serial wire debug host transaction engine, top level. Joins the bit slot
// timer and the packet sequencer. The sequencer's busy flag runs the timer.
// Assumes CLK_HALF >= 2 and a target that changes the line after a
// rising clock edge.
module swd_engine #(
    parameter int DATA_W   = 32,
    parameter int CLK_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_ap,
    input  logic              req_read,
    input  logic [1:0]        req_addr,
    input  logic              req_tsel,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [2:0]        resp_ack,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              resp_parity_err,
    output logic              swclk,
    output logic              swdio_out,
    output logic              swdio_oe,
    input  logic              swdio_in
);
    logic slot_end;

    swd_bitclk #(.HALF(CLK_HALF)) u_bitclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .swclk    (swclk),
        .slot_end (slot_end)
    );

    swd_seq #(.DATA_W(DATA_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (req_valid),
        .req_ap       (req_ap),
        .req_rd       (req_read),
        .req_addr     (req_addr),
        .req_tsel     (req_tsel),
        .req_wdata    (req_wdata),
        .slot_end     (slot_end),
        .swdio_in     (swdio_in),
        .busy_o       (busy),
        .done_o       (done),
        .ack_o        (resp_ack),
        .rdata_o      (resp_rdata),
        .parity_err_o (resp_parity_err),
        .swdio_out_o  (swdio_out),
        .swdio_oe_o   (swdio_oe)
    );

    // R1: no clock toggles on the link while the engine is idle.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> !swclk);

    // R10: the idle line is driven low.
    a_r10_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (swdio_oe && !swdio_out));

endmodule

// File: tb/sim_swd_engine.sv
// Bench for swd_engine: a bit-level target model answers on each rising
// clock edge. Directed corner cases are followed by seeded random packets.
module sim_swd_engine;
    localparam int DW   = 32;
    localparam int HALF = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ap = 1'b0, req_read = 1'b0, req_tsel = 1'b0;
    logic [1:0] req_addr = 2'b00;
    logic [DW-1:0] req_wdata = '0;
    logic busy, done, resp_parity_err, swclk, swdio_out, swdio_oe;
    logic [2:0] resp_ack;
    logic [DW-1:0] resp_rdata;
    logic swdio_in = 1'b0;

    always #4 clk = ~clk;

    swd_engine #(.DATA_W(DW), .CLK_HALF(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ap(req_ap),
        .req_read(req_read), .req_addr(req_addr), .req_tsel(req_tsel),
        .req_wdata(req_wdata), .busy(busy), .done(done), .resp_ack(resp_ack),
        .resp_rdata(resp_rdata), .resp_parity_err(resp_parity_err),
        .swclk(swclk), .swdio_out(swdio_out), .swdio_oe(swdio_oe),
        .swdio_in(swdio_in)
    );

    int n_chk = 0, n_fail = 0;
    logic obs_oe [0:63];
    logic obs_out[0:63];
    logic resp   [0:63];
    int nrise = 0, cyc = 0, last_rise = 0, hi_cnt = 0;
    int per_bad = 0, hi_bad = 0, idle_viol = 0;
    logic prev_clk = 1'b0;

    task automatic chk(input bit ok, input string rq,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_hdr(input logic ap, input logic rd,
                                           input logic [1:0] a);
        logic [7:0] h;
        h[0] = 1'b1; h[1] = ap; h[2] = rd; h[3] = a[0]; h[4] = a[1];
        h[5] = ap ^ rd ^ a[0] ^ a[1]; h[6] = 1'b0; h[7] = 1'b1;
        return h;
    endfunction

    // Target model and link monitor, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (!busy && swclk) idle_viol++;
        if (swclk) hi_cnt++;
        if (swclk && !prev_clk) begin
            if (nrise > 0 && (cyc - last_rise) != 2 * HALF) per_bad++;
            last_rise = cyc;
            if (nrise < 64) begin
                obs_oe[nrise]  = swdio_oe;
                obs_out[nrise] = swdio_out;
                swdio_in       = resp[nrise];
            end
            nrise++;
        end
        if (!swclk && prev_clk) begin
            if (hi_cnt != HALF) hi_bad++;
            hi_cnt = 0;
        end
        prev_clk = swclk;
    end

    task automatic run_txn(input logic ap, input logic rd, input logic [1:0] a,
                           input logic ts, input logic [DW-1:0] wd,
                           input logic [2:0] ackv, input logic [DW-1:0] rdat,
                           input logic flip, input bit poke);
        int exp_n, mm, waitc;
        logic [7:0] h;
        bit ok_ack, dat_w;
        for (int i = 0; i < 64; i++) resp[i] = 1'($urandom);
        for (int i = 0; i < 3; i++) resp[10 + i] = ackv[i];
        for (int i = 0; i < DW; i++) resp[13 + i] = rdat[i];
        resp[13 + DW] = (^rdat) ^ flip;
        while (busy) @(negedge clk);
        nrise = 0;
        req_ap = ap; req_read = rd; req_addr = a; req_tsel = ts; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            // R9: a request while busy must not disturb this packet.
            req_ap = ~ap; req_read = ~rd; req_addr = ~a; req_wdata = ~wd;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        waitc = 0;
        while (!done && waitc < 2000) begin @(negedge clk); waitc++; end
        chk(done == 1'b1, "R9 done seen", 64'(done), 64'd1);
        chk(busy == 1'b0, "R9 busy low with done", 64'(busy), 64'd0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one clock", 64'(done), 64'd0);
        chk(swdio_oe && !swdio_out, "R8 idle line driven low",
            {swdio_oe, swdio_out}, 64'b10);

        ok_ack = (ackv == 3'b001);
        dat_w  = ts || (ok_ack && !rd);
        exp_n  = ts ? 48 : (!ok_ack ? 13 : (rd ? 46 : 48));
        chk(nrise == exp_n, "R4/R5/R6/R7 slot count", 64'(nrise), 64'(exp_n));

        h = exp_hdr(ap, rd, a);
        mm = 0;
        for (int i = 0; i < 10; i++) begin
            if (!obs_oe[i]) mm++;
            if (i < 2 && obs_out[i]) mm++;
            if (i >= 2 && obs_out[i] != h[i-2]) mm++;
        end
        chk(mm == 0, "R2/R3 lead-in and header", 64'(mm), 64'd0);

        mm = 0;
        for (int s = 10; s < exp_n && s < 64; s++) begin
            logic e;
            e = dat_w && (s >= 15);
            if (obs_oe[s] != e) mm++;
        end
        chk(mm == 0, "R8 output enable per slot", 64'(mm), 64'd0);

        if (dat_w) begin
            mm = 0;
            for (int i = 0; i < DW; i++) if (obs_out[15 + i] != wd[i]) mm++;
            if (obs_out[15 + DW] != ^wd) mm++;
            chk(mm == 0, ts ? "R7 target-select data" : "R5 write data and parity",
                64'(mm), 64'd0);
        end
        chk(resp_ack == (ts ? 3'b000 : ackv), ts ? "R7 ack reads zero" : "R4 ack value",
            64'(resp_ack), 64'(ts ? 3'b000 : ackv));
        if (!ts && ok_ack && rd) begin
            chk(resp_rdata == rdat, "R6 read data", 64'(resp_rdata), 64'(rdat));
            chk(resp_parity_err == flip, "R6 parity flag",
                64'(resp_parity_err), 64'(flip));
        end else begin
            chk(resp_parity_err == 1'b0, "R6 no parity flag off reads",
                64'(resp_parity_err), 64'd0);
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd13579);
        repeat (3) @(negedge clk);
        // R10: reset state.
        chk(swclk == 1'b0, "R10 swclk", 64'(swclk), 64'd0);
        chk(swdio_oe && !swdio_out, "R10 line", {swdio_oe, swdio_out}, 64'b10);
        chk(!busy && !done, "R10 busy/done", {busy, done}, 64'd0);
        chk(resp_ack == 3'b000, "R10 ack", 64'(resp_ack), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run_txn(1'b0, 1'b1, 2'b00, 1'b0, '0, 3'b001, 32'h0BAD_F00D, 1'b0, 0); // R6
        run_txn(1'b1, 1'b1, 2'b11, 1'b0, '0, 3'b001, 32'h8000_0001, 1'b1, 0); // R6 flip
        run_txn(1'b1, 1'b0, 2'b01, 1'b0, 32'hA5C3_0FF1, 3'b001, '0, 1'b0, 0); // R5
        run_txn(1'b0, 1'b0, 2'b11, 1'b1, 32'h1357_9BDF, 3'b100, '0, 1'b0, 0); // R7
        run_txn(1'b0, 1'b1, 2'b10, 1'b0, '0, 3'b010, 32'hFFFF_FFFF, 1'b0, 0); // R4 wait
        run_txn(1'b1, 1'b0, 2'b00, 1'b0, 32'h1, 3'b100, '0, 1'b0, 0);        // R4 fault
        run_txn(1'b0, 1'b0, 2'b01, 1'b0, 32'h2, 3'b111, '0, 1'b0, 0);        // R4 invalid
        run_txn(1'b1, 1'b1, 2'b01, 1'b0, '0, 3'b000, 32'h5, 1'b0, 0);        // R4 none
        run_txn(1'b1, 1'b0, 2'b10, 1'b0, 32'hDEAD_BEEF, 3'b001, '0, 1'b0, 1); // R9
        run_txn(1'b0, 1'b1, 2'b01, 1'b0, '0, 3'b001, 32'h7777_0000, 1'b0, 1); // R9

        for (int k = 0; k < 40; k++) begin
            logic [2:0] av;
            int pick;
            pick = int'($urandom % 6);
            av = (pick < 3) ? 3'b001 : (pick == 3) ? 3'b010 :
                 (pick == 4) ? 3'b100 : 3'($urandom);
            run_txn(1'($urandom), 1'($urandom), 2'($urandom), ($urandom % 5) == 0,
                    $urandom, av, $urandom, 1'($urandom), 0);
        end

        chk(per_bad == 0, "R1 slot period", 64'(per_bad), 64'd0);
        chk(hi_bad == 0, "R1 clock high time", 64'(hi_bad), 64'd0);
        chk(idle_viol == 0, "R1 clock quiet when idle", 64'(idle_viol), 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule